// File: doc/BRIEF.md
# External Interrupt Broadcast Distributor

This block fans each external interrupt line out to a programmable group of cores in a cluster. Every line has a core-enable word: bit k set routes the line to core k. Every line also has a claim word, so that several cores that see the same broadcast can settle which one of them services it. A core writes a word with only its own bit set. It then reads the claim word back, and it owns the interrupt only if the value it reads equals the word it wrote. The owner rearms the claim by writing all ones once it is done.

Each core has its own 32-bit register port, with a write strobe, a read strobe, a 16-bit byte address and write data. Read data is registered and appears one cycle after the read strobe. The block drives one registered interrupt vector per core, and it has two read-only words that report its configured core count and line count. Several cores may write the same register in one cycle; a fixed priority settles which write counts.

Top module: `irq_bcast_dist`

## Requirements
- R1: After reset every core-enable word reads 0x1, every claim word reads 0xFFFFFFFF and every interrupt output is 0.
- R2: A write to byte address 0x4000 + 4·n, for n below the line count, stores the low core-count bits of the data as line n's core-enable word. A read of that address returns the stored bits with all higher bits zero.
- R3: Output bit k·NI + n, which is core k's vector bit n, equals interrupt input n ANDed with bit k of line n's core-enable word. Both are taken from the previous clock edge.
- R4: When line n's claim word is free (all ones), a write to byte address 0x8000 + 4·n of a word with exactly one bit set, at a position below the core count, takes the claim. A read then returns that word.
- R5: While a claim is held, any further write of a one-hot word to that claim address is ignored, and a read still returns the holder's word.
- R6: A write of 0xFFFFFFFF to a claim address always releases the claim, whatever the claim state. A read then returns 0xFFFFFFFF, and a new one-hot write can take the claim.
- R7: A claim write whose data is neither 0xFFFFFFFF nor a valid one-hot word is ignored. This covers zero, a word with two or more bits set, and a one-hot bit at or above the core count.
- R8: When several ports write the same register in one cycle, only the word from the lowest-numbered port is applied. R4 to R7 judge that word as if it had been the only write.
- R9: Reads of byte address 0xC084 return the core count and reads of 0xC090 return the line count. Writes to either address change nothing.
- R10: Read data appears on a port's rdata slice one clock edge after its read strobe and holds until that port's next read. Unmapped, misaligned or out-of-range addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NI | External interrupt lines |
| bus_we | input | NC | Per-port write strobe |
| bus_re | input | NC | Per-port read strobe |
| bus_addr | input | NC*16 | Per-port byte address, port k at [16k +: 16] |
| bus_wdata | input | NC*32 | Per-port write data, port k at [32k +: 32] |
| bus_rdata | output | NC*32 | Per-port registered read data, port k at [32k +: 32] |
| irq_out | output | NC*NI | Per-core interrupt vectors, core k at [NI·k +: NI] |

## Verification
The bench builds the block with four cores and eight lines. With four cores, the bench can drive two-way and four-way simultaneous claims and write one-hot bits above the core count. With eight lines, the first address past the last line can be probed, and the core-enable patterns can differ from line to line. Upper data bits above the fourth are exercised on both the core-enable and claim paths.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam logic [15:0] CFG_CORES_ADDR = 16'hC084;
  localparam logic [15:0] CFG_LINES_ADDR = 16'hC090;
  localparam logic [1:0]  REGION_ENABLE  = 2'b01;
  localparam logic [1:0]  REGION_CLAIM   = 2'b10;
  localparam logic [31:0] CLAIM_FREE     = 32'hFFFF_FFFF;
endpackage

// File: rtl/irqd_port_decode.sv
module irqd_port_decode #(
  parameter int NI = 8,
  parameter int IW = 3
) (
  input  logic [15:0]   addr,
  output logic          hit_enable,
  output logic          hit_claim,
  output logic [IW-1:0] line_idx
);
  import irqd_pkg::*;
  logic in_range;

  always_comb begin
    in_range   = (int'(addr[13:2]) < NI) && (addr[1:0] == 2'b00);
    hit_enable = in_range && (addr[15:14] == REGION_ENABLE);
    hit_claim  = in_range && (addr[15:14] == REGION_CLAIM);
    line_idx   = addr[2 +: IW];
  end
endmodule

// File: rtl/irqd_line.sv
module irqd_line #(
  parameter int NC = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           irq_in,
  input  logic [NC-1:0]  en_hit,
  input  logic [NC-1:0]  cl_hit,
  input  logic [NC*32-1:0] wdata_all,
  output logic [NC-1:0]  en_q,
  output logic           cl_free,
  output logic [NC-1:0]  cl_own,
  output logic [NC-1:0]  irq_q
);
  import irqd_pkg::*;
  logic          en_we, cl_we;
  logic [NC-1:0] en_word;
  logic [31:0]   cl_word;
  logic          cl_valid;

  // descending scan: the lowest-numbered port is assigned last and wins
  always_comb begin
    en_we   = 1'b0;
    cl_we   = 1'b0;
    en_word = en_q;
    cl_word = CLAIM_FREE;
    for (int k = NC - 1; k >= 0; k--) begin
      if (en_hit[k]) begin
        en_we   = 1'b1;
        en_word = wdata_all[k*32 +: NC];
      end
      if (cl_hit[k]) begin
        cl_we   = 1'b1;
        cl_word = wdata_all[k*32 +: 32];
      end
    end
    cl_valid = $onehot(cl_word) && ((cl_word >> NC) == 32'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= NC'(1);
      cl_free <= 1'b1;
      cl_own  <= '0;
      irq_q   <= '0;
    end else begin
      if (en_we) en_q <= en_word;
      if (cl_we) begin
        if (cl_word == CLAIM_FREE) begin
          cl_free <= 1'b1;
          cl_own  <= '0;
        end else if (cl_free && cl_valid) begin
          cl_free <= 1'b0;
          cl_own  <= cl_word[NC-1:0];
        end
      end
      irq_q <= en_q & {NC{irq_in}};
    end
  end
endmodule

// File: rtl/irqd_rd_port.sv
module irqd_rd_port #(
  parameter int NC = 4,
  parameter int NI = 8,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             re,
  input  logic [15:0]      addr,
  input  logic             hit_enable,
  input  logic             hit_claim,
  input  logic [IW-1:0]    line_idx,
  input  logic [NI*NC-1:0] en_flat,
  input  logic [NI*NC-1:0] own_flat,
  input  logic [NI-1:0]    free_vec,
  output logic [31:0]      rdata
);
  import irqd_pkg::*;
  localparam logic [31:0] CORES_WORD = 32'(NC);
  localparam logic [31:0] LINES_WORD = 32'(NI);
  logic [31:0] rd_next;

  always_comb begin
    rd_next = 32'd0;
    if (hit_enable)
      rd_next = 32'(en_flat[int'(line_idx)*NC +: NC]);
    else if (hit_claim)
      rd_next = free_vec[line_idx] ? CLAIM_FREE : 32'(own_flat[int'(line_idx)*NC +: NC]);
    else if (addr == CFG_CORES_ADDR)
      rd_next = CORES_WORD;
    else if (addr == CFG_LINES_ADDR)
      rd_next = LINES_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 32'd0;
    else if (re) rdata <= rd_next;
  end
endmodule

// File: rtl/irq_bcast_dist.sv
module irq_bcast_dist #(
  parameter int NC = 4,
  parameter int NI = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NI-1:0]    irq_in,
  input  logic [NC-1:0]    bus_we,
  input  logic [NC-1:0]    bus_re,
  input  logic [NC*16-1:0] bus_addr,
  input  logic [NC*32-1:0] bus_wdata,
  output logic [NC*32-1:0] bus_rdata,
  output logic [NC*NI-1:0] irq_out
);
  localparam int IW = (NI > 1) ? $clog2(NI) : 1;

  logic [NC-1:0]    p_en, p_cl;
  logic [IW-1:0]    p_idx [NC];
  logic [NI*NC-1:0] en_flat, own_flat;
  logic [NI-1:0]    free_vec;

  for (genvar k = 0; k < NC; k++) begin : g_port
    irqd_port_decode #(.NI(NI), .IW(IW)) u_dec (
      .addr      (bus_addr[k*16 +: 16]),
      .hit_enable(p_en[k]),
      .hit_claim (p_cl[k]),
      .line_idx  (p_idx[k])
    );
    irqd_rd_port #(.NC(NC), .NI(NI), .IW(IW)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .re        (bus_re[k]),
      .addr      (bus_addr[k*16 +: 16]),
      .hit_enable(p_en[k]),
      .hit_claim (p_cl[k]),
      .line_idx  (p_idx[k]),
      .en_flat   (en_flat),
      .own_flat  (own_flat),
      .free_vec  (free_vec),
      .rdata     (bus_rdata[k*32 +: 32])
    );
  end

  for (genvar n = 0; n < NI; n++) begin : g_line
    logic [NC-1:0] en_hit, cl_hit, irq_q;
    always_comb begin
      for (int k = 0; k < NC; k++) begin
        en_hit[k] = bus_we[k] && p_en[k] && (p_idx[k] == IW'(n));
        cl_hit[k] = bus_we[k] && p_cl[k] && (p_idx[k] == IW'(n));
      end
    end
    irqd_line #(.NC(NC)) u_line (
      .clk      (clk),
      .rst      (rst),
      .irq_in   (irq_in[n]),
      .en_hit   (en_hit),
      .cl_hit   (cl_hit),
      .wdata_all(bus_wdata),
      .en_q     (en_flat[n*NC +: NC]),
      .cl_free  (free_vec[n]),
      .cl_own   (own_flat[n*NC +: NC]),
      .irq_q    (irq_q)
    );
    for (genvar k = 0; k < NC; k++) begin : g_out
      assign irq_out[k*NI + n] = irq_q[k];
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
  parameter int NC = 4,
  parameter int NI = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NI-1:0]    irq_in,
  input logic [NC-1:0]    bus_re,
  input logic [NC*16-1:0] bus_addr,
  input logic [NC*32-1:0] bus_rdata,
  input logic [NC*NI-1:0] irq_out,
  input logic [NI*NC-1:0] en_flat,
  input logic [NI*NC-1:0] own_flat,
  input logic [NI-1:0]    free_vec
);
  for (genvar n = 0; n < NI; n++) begin : g_l
    // R4: a held claim names exactly one core
    p_claim_onehot_r4: assert property (@(posedge clk) disable iff (rst)
      !free_vec[n] |-> $onehot(own_flat[n*NC +: NC]));
    // R5: a held claim stays put until released
    p_claim_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      !free_vec[n] |=> (free_vec[n] || $stable(own_flat[n*NC +: NC])));
    for (genvar k = 0; k < NC; k++) begin : g_c
      // R3: routed output follows input gated by the enable bit
      p_route_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (irq_out[k*NI + n] == $past(irq_in[n] && en_flat[n*NC + k])));
    end
  end
  for (genvar k = 0; k < NC; k++) begin : g_p
    // R9: configuration words
    p_cfg_cores_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_re[k] && bus_addr[k*16 +: 16] == 16'hC084) |=> (bus_rdata[k*32 +: 32] == 32'(NC)));
    p_cfg_lines_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_re[k] && bus_addr[k*16 +: 16] == 16'hC090) |=> (bus_rdata[k*32 +: 32] == 32'(NI)));
  end
endmodule

bind irq_bcast_dist irqd_chk #(.NC(NC), .NI(NI)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_in   (irq_in),
  .bus_re   (bus_re),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out),
  .en_flat  (en_flat),
  .own_flat (own_flat),
  .free_vec (free_vec)
);

// File: tb/sim_irq_bcast_dist.sv
`timescale 1ns/1ps
module sim_irq_bcast_dist;
  localparam int NC = 4;
  localparam int NI = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NI-1:0]    irq_in = '0;
  logic [NC-1:0]    bus_we = '0;
  logic [NC-1:0]    bus_re = '0;
  logic [NC*16-1:0] bus_addr = '0;
  logic [NC*32-1:0] bus_wdata = '0;
  logic [NC*32-1:0] bus_rdata;
  logic [NC*NI-1:0] irq_out;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  irq_bcast_dist #(.NC(NC), .NI(NI)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0]      m_en [NI];
  logic [31:0]      m_cl [NI];
  logic [31:0]      m_rd [NC];
  logic [NC*NI-1:0] m_irq;

  function automatic logic [31:0] model_read(input logic [15:0] a);
    int off;
    off = int'(a);
    if (off % 4 != 0) return 32'd0;
    if (off >= 'h4000 && off < 'h4000 + 4*NI) return m_en[(off - 'h4000) / 4];
    if (off >= 'h8000 && off < 'h8000 + 4*NI) return m_cl[(off - 'h8000) / 4];
    if (off == 'hC084) return NC;
    if (off == 'hC090) return NI;
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NI; n++) begin m_en[n] = 32'd1; m_cl[n] = 32'hFFFF_FFFF; end
      for (int k = 0; k < NC; k++) m_rd[k] = 32'd0;
      m_irq = '0;
    end else begin
      for (int k = 0; k < NC; k++)
        for (int n = 0; n < NI; n++)
          m_irq[k*NI + n] = irq_in[n] & m_en[n][k];
      for (int k = 0; k < NC; k++)
        if (bus_re[k]) m_rd[k] = model_read(bus_addr[k*16 +: 16]);
      for (int n = 0; n < NI; n++) begin
        int win;
        logic [31:0] w;
        win = -1;
        for (int k = 0; k < NC; k++)
          if (win < 0 && bus_we[k] && int'(bus_addr[k*16 +: 16]) == 'h4000 + 4*n) win = k;
        if (win >= 0) m_en[n] = bus_wdata[win*32 +: 32] & ((32'd1 << NC) - 1);
        win = -1;
        for (int k = 0; k < NC; k++)
          if (win < 0 && bus_we[k] && int'(bus_addr[k*16 +: 16]) == 'h8000 + 4*n) win = k;
        if (win >= 0) begin
          w = bus_wdata[win*32 +: 32];
          if (w == 32'hFFFF_FFFF) m_cl[n] = w;
          else if (m_cl[n] == 32'hFFFF_FFFF && $countones(w) == 1 && w < (32'd1 << NC)) m_cl[n] = w;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (irq_out !== m_irq) begin
        bad++;
        $display("FAIL R3 irq_out actual=%h expected=%h", irq_out, m_irq);
      end
      for (int k = 0; k < NC; k++) begin
        total++;
        if (bus_rdata[k*32 +: 32] !== m_rd[k]) begin
          bad++;
          $display("FAIL %s port%0d rdata actual=%h expected=%h", cur_tag, k, bus_rdata[k*32 +: 32], m_rd[k]);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    bus_we = '0;
    bus_re = '0;
  endtask

  task automatic put(input int k, input logic [15:0] a, input logic [31:0] d);
    bus_we[k] = 1'b1;
    bus_addr[k*16 +: 16] = a;
    bus_wdata[k*32 +: 32] = d;
  endtask

  task automatic get(input int k, input logic [15:0] a);
    bus_re[k] = 1'b1;
    bus_addr[k*16 +: 16] = a;
  endtask

  task automatic wr1(input int k, input logic [15:0] a, input logic [31:0] d);
    put(k, a, d); step();
  endtask

  task automatic rd1(input int k, input logic [15:0] a);
    get(k, a); step();
  endtask

  function automatic logic [15:0] en_a(input int n); return 16'(32'h4000 + 4*n); endfunction
  function automatic logic [15:0] cl_a(input int n); return 16'(32'h8000 + 4*n); endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset contents
    cur_tag = "R1";
    total++;
    if (irq_out !== '0 || bus_rdata !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%h/%h expected=0", irq_out, bus_rdata);
    end
    for (int n = 0; n < NI; n++) begin get(0, en_a(n)); get(1, cl_a(n)); step(); end
    irq_in = 8'hFF; step(); step();
    // R2: enable write and readback, upper bits dropped
    cur_tag = "R2";
    wr1(2, en_a(2), 32'hFFFF_FFF6);
    rd1(0, en_a(2));
    wr1(1, en_a(7), 32'h0000_000F);
    rd1(3, en_a(7));
    // R3: routing under several input patterns
    cur_tag = "R3";
    wr1(0, en_a(0), 32'h0);
    wr1(0, en_a(5), 32'hA);
    foreach (irq_in[i]) begin irq_in = 8'(1 << i); step(); end
    irq_in = 8'hA5; step(); irq_in = 8'h5A; step(); irq_in = 8'h00; step();
    // R4: first claim taken
    cur_tag = "R4";
    wr1(2, cl_a(3), 32'h4);
    rd1(2, cl_a(3));
    // R5: later claim ignored
    cur_tag = "R5";
    wr1(1, cl_a(3), 32'h2);
    rd1(1, cl_a(3));
    // R6: release and rearm
    cur_tag = "R6";
    wr1(0, cl_a(3), 32'hFFFF_FFFF);
    rd1(0, cl_a(3));
    wr1(1, cl_a(3), 32'h2);
    rd1(3, cl_a(3));
    wr1(3, cl_a(3), 32'hFFFF_FFFF);
    // R7: malformed claim words ignored
    cur_tag = "R7";
    wr1(0, cl_a(6), 32'h3); rd1(0, cl_a(6));
    wr1(0, cl_a(6), 32'h0); rd1(0, cl_a(6));
    wr1(0, cl_a(6), 32'h10); rd1(0, cl_a(6));
    wr1(0, cl_a(6), 32'h8000_0000); rd1(0, cl_a(6));
    // R8: simultaneous writers, lowest port wins
    cur_tag = "R8";
    put(1, cl_a(5), 32'h2); put(3, cl_a(5), 32'h8); step();
    rd1(2, cl_a(5));
    wr1(0, cl_a(5), 32'hFFFF_FFFF);
    put(0, cl_a(5), 32'h3); put(2, cl_a(5), 32'h4); step();
    rd1(2, cl_a(5));
    put(0, en_a(4), 32'h5); put(2, en_a(4), 32'hA); step();
    rd1(1, en_a(4));
    put(0, cl_a(1), 32'h1); put(1, cl_a(1), 32'h2); put(2, cl_a(1), 32'h4); put(3, cl_a(1), 32'h8); step();
    rd1(3, cl_a(1));
    // R9: configuration words, writes ignored
    cur_tag = "R9";
    get(0, 16'hC084); get(1, 16'hC090); step();
    put(0, 16'hC084, 32'h77); put(1, 16'hC090, 32'h99); step();
    get(2, 16'hC084); get(3, 16'hC090); step();
    // R10: unmapped, misaligned, out of range, hold without strobe
    cur_tag = "R10";
    rd1(0, en_a(NI));
    rd1(1, cl_a(NI));
    rd1(2, 16'h1234);
    rd1(3, 16'h4006);
    rd1(0, en_a(7));
    step(); step();
    irq_in = 8'hFF; step(); step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule